// File: doc/BRIEF.md
# USB Function Interrupt Aggregator

This block gathers single-cycle event pulses from a USB device controller and reduces them to two level-type interrupt request lines. The first line, `irq_ep0`, serves the control endpoint. It fires on the following events:

- a successful receive;
- a successful send;
- the clearing of the data-end condition;
- an aborted control transfer (setup-end).

The second line, `irq_func`, gathers the remaining events:

- completions on data endpoints 1 to 4 in both directions;
- flow errors on all nine endpoints;
- the arming of an IN endpoint;
- a corrupted final handshake in the data stage of a control read.

Every source latches into a sticky status flag. Each flag has an enable bit of its own, and only enabled flags reach an interrupt line. Software uses a small word-wide register port. It reads the flags, clears them by writing ones, and writes the enables. After reset every source is masked, and that includes the data-end event.

Top module: `usb_irq_agg`

## Requirements
- R1: An `ev_ep0` pulse sampled at a clock edge sets the matching bit of the control status register (address 0) from that edge onward. The bits are: bit 0 receive-ok, bit 1 send-ok, bit 2 data-end cleared, bit 3 setup-end.
- R2: After reset all flags and all enable bits read as zero, so every source is masked, the data-end source included. Both interrupt lines are low.
- R3: An event pulse sets the matching bit of the function status register (address 2). The bits are:
  - bits 3:0 for IN completions on endpoints 1 to 4;
  - bits 7:4 for OUT completions on endpoints 1 to 4;
  - bits 16:8 for `ev_err` bits 0..8, where bit 0 is endpoint 0, bits 1..4 are IN 1..4 and bits 5..8 are OUT 1..4;
  - bits 20:17 for IN-arm on endpoints 1 to 4;
  - bit 21 for the corrupted final handshake.
- R4: A write to a status address clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R5: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: `irq_ep0` is high exactly when some control flag and its enable bit (address 1) are both set. `irq_func` is high exactly when some function flag and its enable bit (address 3) are both set. Each line stays high until every contributing flag is cleared.
- R7: A disabled source still sets its status flag but does not raise an interrupt line.
- R8: Writing an enable address stores the written bits. Reading it returns those bits, with the bits above the field width reading as zero.
- R9: A set flag stays set across cycles in which its status register is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 control status, 1 control enable, 2 function status, 3 function enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| ev_ep0 | input | 4 | Control endpoint event pulses |
| ev_in_done | input | NUM_EP | IN transfer complete, endpoints 1..NUM_EP |
| ev_out_done | input | NUM_EP | OUT transfer complete, endpoints 1..NUM_EP |
| ev_err | input | 2*NUM_EP+1 | Data flow error per endpoint |
| ev_in_arm | input | NUM_EP | IN endpoint enabled |
| ev_ack_bad | input | 1 | Final handshake of a control-read data stage corrupted |
| irq_ep0 | output | 1 | Control endpoint interrupt, level |
| irq_func | output | 1 | Function interrupt, level |

## Verification
The bench pulses every control source under each of the sixteen enable patterns. This separates routing errors between a flag and its enable from errors in the OR reduction. It also pulses every function source twice: once with only its own enable set and once with every enable set except its own. A bit that leaks into a neighbour's position then shows up in the read-back value or on the interrupt line. Separate patterns write zeros to a set flag, collide an event with its own clear, and fill the enable registers with all ones. These patterns isolate the clear mask, the set-over-clear priority and the field width.

// File: rtl/usb_irq_agg.sv
module usb_irq_agg #(
  parameter int NUM_EP = 4,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [3:0]        ev_ep0,
  input  logic [NUM_EP-1:0] ev_in_done,
  input  logic [NUM_EP-1:0] ev_out_done,
  input  logic [2*NUM_EP:0] ev_err,
  input  logic [NUM_EP-1:0] ev_in_arm,
  input  logic              ev_ack_bad,
  output logic              irq_ep0,
  output logic              irq_func
);
  localparam int FW = 5*NUM_EP + 2;
  localparam logic [3:0] EP0_EN_RST = 4'b0000;

  logic [3:0]    st0, en0;
  logic [FW-1:0] stf, enf;
  logic [FW-1:0] ev_func;

  assign ev_func = {ev_ack_bad, ev_in_arm, ev_err, ev_out_done, ev_in_done};

  wire wr_st0 = reg_wr && reg_addr == 2'd0;
  wire wr_en0 = reg_wr && reg_addr == 2'd1;
  wire wr_stf = reg_wr && reg_addr == 2'd2;
  wire wr_enf = reg_wr && reg_addr == 2'd3;

  wire [3:0]    clr0 = wr_st0 ? reg_wdata[3:0] : 4'b0;
  wire [FW-1:0] clrf = wr_stf ? reg_wdata[FW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st0 <= '0;
      en0 <= EP0_EN_RST;
      stf <= '0;
      enf <= '0;
    end else begin
      st0 <= (st0 & ~clr0) | ev_ep0;
      stf <= (stf & ~clrf) | ev_func;
      if (wr_en0) en0 <= reg_wdata[3:0];
      if (wr_enf) enf <= reg_wdata[FW-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DW'(st0);
      2'd1:    reg_rdata = DW'(en0);
      2'd2:    reg_rdata = DW'(stf);
      default: reg_rdata = DW'(enf);
    endcase
  end

  assign irq_ep0  = |(st0 & en0);
  assign irq_func = |(stf & enf);
endmodule

// File: rtl/usb_irq_agg_chk.sv
module usb_irq_agg_chk #(
  parameter int FW = 22,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic [3:0]    ev_ep0,
  input logic [FW-1:0] ev_func,
  input logic [3:0]    st0,
  input logic [3:0]    en0,
  input logic [FW-1:0] stf,
  input logic [FW-1:0] enf,
  input logic          irq_ep0,
  input logic          irq_func
);
  // R1
  ep0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ep0 != 4'b0) |=> ((st0 & $past(ev_ep0)) == $past(ev_ep0)));

  // R3
  func_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_func != '0) |=> ((stf & $past(ev_func)) == $past(ev_func)));

  // R9
  func_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd2) |=> ((stf & $past(stf)) == $past(stf)));

  // R4
  func_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && ev_func == '0)
      |=> ((stf & $past(reg_wdata[FW-1:0])) == '0));

  // R6
  ep0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[3:0] == 4'hF && ev_ep0 == 4'b0) |=> !irq_ep0);

  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en0 == 4'b0 && enf == '0 && !irq_ep0 && !irq_func));
endmodule

bind usb_irq_agg usb_irq_agg_chk #(.FW(FW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .ev_ep0(ev_ep0), .ev_func(ev_func),
  .st0(st0), .en0(en0), .stf(stf), .enf(enf),
  .irq_ep0(irq_ep0), .irq_func(irq_func)
);

// File: tb/test_usb_irq_agg.sv
`timescale 1ns/1ps
module test_usb_irq_agg;
  localparam int NUM_EP = 4;
  localparam int DW = 32;
  localparam int FW = 5*NUM_EP + 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic [3:0] ev_ep0 = 0;
  logic [NUM_EP-1:0] ev_in_done = 0, ev_out_done = 0, ev_in_arm = 0;
  logic [2*NUM_EP:0] ev_err = 0;
  logic ev_ack_bad = 0;
  logic irq_ep0, irq_func;
  int n_run = 0, n_fail = 0;
  logic [DW-1:0] v;

  always #2 clk = ~clk;

  usb_irq_agg #(.NUM_EP(NUM_EP), .DW(DW)) i_usb_irq_agg (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_ep0(ev_ep0),
    .ev_in_done(ev_in_done), .ev_out_done(ev_out_done), .ev_err(ev_err),
    .ev_in_arm(ev_in_arm), .ev_ack_bad(ev_ack_bad),
    .irq_ep0(irq_ep0), .irq_func(irq_func));

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wr = 1; reg_wdata = d; tick; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic set_func(input logic [FW-1:0] x);
    {ev_ack_bad, ev_in_arm, ev_err, ev_out_done, ev_in_done} = x;
  endtask

  initial begin
    #40000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    // R2 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R2", v, 0); end
    chk("R2 irq", {30'b0, irq_ep0, irq_func}, 0);

    // R1 R6 R7 control sources under every enable pattern
    for (int en = 0; en < 16; en++) begin
      for (int s = 0; s < 4; s++) begin
        wr(1, DW'(en));
        ev_ep0 = 4'(1 << s); tick; ev_ep0 = 0;
        rd(0, v); chk("R1", v, DW'(1 << s));
        chk("R6/R7 irq_ep0", DW'(irq_ep0), DW'((en >> s) & 1));
        wr(0, DW'(1 << s));
        rd(0, v); chk("R4", v, 0);
        chk("R6 irq_ep0 low", DW'(irq_ep0), 0);
      end
    end

    // R3 R6 R7 function sources, own enable only and all-but-own
    for (int b = 0; b < FW; b++) begin
      for (int m = 0; m < 2; m++) begin
        wr(3, m ? DW'(1 << b) : DW'(~(1 << b)));
        set_func(FW'(1 << b)); tick; set_func('0);
        rd(2, v); chk("R3", v, DW'(1 << b));
        chk("R6/R7 irq_func", DW'(irq_func), DW'(m));
        wr(2, DW'(1 << b));
        rd(2, v); chk("R4", v, 0);
      end
    end

    // R4 writing zeros leaves flags; R9 sticky over idle cycles
    wr(3, 0);
    set_func(FW'(5)); tick; set_func('0);
    wr(2, 0); tick; tick;
    rd(2, v); chk("R4/R9", v, 5);
    wr(2, 1);
    rd(2, v); chk("R4 partial", v, 4);
    wr(2, '1);

    // R5 event beats same-cycle clear
    wr(1, 4'hF);
    reg_addr = 0; reg_wr = 1; reg_wdata = 4'h2; ev_ep0 = 4'h2; tick;
    reg_wr = 0; ev_ep0 = 0;
    rd(0, v); chk("R5", v, 2);
    chk("R5 irq", DW'(irq_ep0), 1);
    wr(0, 4'hF);

    // R6 level holds until every flag cleared
    wr(3, '1);
    set_func(FW'(3)); tick; set_func('0);
    wr(2, 1); chk("R6 hold", DW'(irq_func), 1);
    wr(2, 2); chk("R6 drop", DW'(irq_func), 0);

    // R8 enable read-back width
    wr(1, '1); rd(1, v); chk("R8 en0", v, 32'hF);
    wr(3, '1); rd(3, v); chk("R8 enf", v, DW'((1 << FW) - 1));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule